// File: doc/BRIEF.md
# Clock Frequency Trim Calculator

This block turns a requested frequency offset into the 64-bit increment that a nanosecond time counter adds on every core clock cycle. The increment is a 32.32 fixed-point value: the upper 32 bits are whole nanoseconds and the lower 32 bits are a binary fraction. The offset arrives as a signed value in scaled parts-per-million, where one ppm is 65536 units. The core clock rate is not an input. It is rebuilt from a 6-bit multiplier field of a boot configuration word, times a 50 MHz base.

A calculation runs in four steps. A restoring divider first gives the nominal increment. The offset magnitude is converted to parts per billion. A shift-add multiplier scales the nominal increment by that ppb value. A second pass of the same divider removes the 10^9 factor, and the result is then added to or subtracted from the nominal increment.

The request side is a valid/ready handshake. `req_ready` is high only while the unit is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. Holding `req_valid` high while `req_ready` is low has no effect, so the requester must keep its operands stable until the request is taken. The result side has no back-pressure. `res_valid` pulses once, and `result` and `res_err` then hold until the next calculation completes.

Top module: `freq_trim_calc`

## Requirements
- R1: The multiplier is `boot_word[38:33]` when `cfg_present` is 1. When `cfg_present` is 0 it is 16, and `boot_word` is then ignored. No other bit of `boot_word` affects the result.
- R2: The nominal increment is floor(10^9 * 2^32 / (50,000,000 * multiplier)). With an offset that converts to 0 ppb, the result equals this nominal value.
- R3: `scaled_ppm` is a two's-complement value of PPM_W bits. Its magnitude m gives ppb = floor((m + 1) * 125 / 8192). So a magnitude of 64 gives 0 ppb, and 65 gives 1 ppb.
- R4: The adjustment is floor(nominal * ppb / 10^9). The result is nominal + adjustment for an offset of zero or more, and nominal - adjustment for a negative offset.
- R5: The extreme offsets, the most negative code and the most positive code, both give exact results. The intermediate product is kept at 128 bits, so it does not overflow.
- R6: A multiplier of 0 gives `result` = 0 with `res_err` = 1. Every other calculation ends with `res_err` = 0.
- R7: `req_ready` is high only when the unit is idle, and it goes low on the cycle after a request is taken. While the unit is busy, `req_valid` is ignored: it neither changes the result in progress nor starts another calculation.
- R8: `res_valid` is high for exactly one cycle per accepted request. `result` and `res_err` change only on that cycle and otherwise hold their value.
- R9: After reset, `req_ready` = 1, `res_valid` = 0, `result` = 0 and `res_err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| cfg_present | input | 1 | Boot word is available; when 0, multiplier 16 is used |
| boot_word | input | 64 | Boot configuration word; bits 38:33 hold the multiplier |
| scaled_ppm | input | PPM_W | Signed offset, 65536 units per ppm |
| res_valid | output | 1 | One-cycle pulse: result is updated |
| result | output | 64 | 32.32 increment in nanoseconds per cycle |
| res_err | output | 1 | Last calculation had a multiplier of zero |

## Verification
The first set of stimuli uses a zero offset across multipliers 1, 16, 20 and 63. This isolates the first division from the rest of the path, and a boot word with every non-field bit set shows whether the field extraction works or whether absent configuration falls back to 16. Offsets of ±1 ppm at two clock rates show whether the sign picks addition or subtraction and whether the result depends on the nominal value. Offsets of 64, 65 and -65 sit on the point where the ppb conversion first turns nonzero. The two extreme codes exercise the full width of the product. Directed runs then offer requests while the unit is busy, send a zero multiplier, and idle after a result to show that the output holds.

// File: rtl/trim_pkg.sv
package trim_pkg;

  localparam int unsigned  INC_W     = 64;
  localparam int unsigned  NUM_W     = 128;
  localparam int unsigned  DEN_W     = 64;
  localparam longint unsigned BASE_HZ = 64'd50_000_000;
  localparam longint unsigned NS_PER_S = 64'd1_000_000_000;
  localparam int unsigned  PPB_MUL   = 125;
  localparam int unsigned  PPB_SHIFT = 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_NOM,
    ST_MUL,
    ST_DIV_ADJ,
    ST_ZERO
  } trim_state_e;

endpackage

// File: rtl/trim_div.sv
// Restoring divider: one quotient bit per cycle, NW cycles per division.
module trim_div #(
  parameter int unsigned NW = 128,
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int unsigned CW = $clog2(NW + 1);

  logic [NW-1:0] n_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] r_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          fits;

  always_comb begin
    trial = {r_q, n_q[NW-1]};
    diff  = trial - {1'b0, d_q};
    fits  = (trial >= {1'b0, d_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      d_q    <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy_q) begin
        n_q    <= num;
        d_q    <= den;
        r_q    <= '0;
        cnt_q  <= CW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        n_q   <= {n_q[NW-2:0], fits};
        r_q   <= fits ? diff[DW-1:0] : trial[DW-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quo = n_q;

endmodule

// File: rtl/trim_mul.sv
// Shift-add multiplier: one multiplier bit per cycle, BW cycles per product.
module trim_mul #(
  parameter int unsigned AW = 64,
  parameter int unsigned BW = 32,
  parameter int unsigned PW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic          done,
  output logic [PW-1:0] prod
);
  localparam int unsigned CW = $clog2(BW + 1);

  logic [PW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic [PW-1:0] acc_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy_q) begin
        a_q    <= PW'(a);
        b_q    <= b;
        acc_q  <= '0;
        cnt_q  <= CW'(BW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (b_q[0]) acc_q <= acc_q + a_q;
        a_q   <= a_q << 1;
        b_q   <= b_q >> 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign prod = acc_q;

endmodule

// File: rtl/freq_trim_calc.sv
module freq_trim_calc
  import trim_pkg::*;
#(
  parameter int unsigned PPM_W   = 32,
  parameter int unsigned MUL_LSB = 33,
  parameter int unsigned MUL_W   = 6,
  parameter int unsigned DEF_MUL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             cfg_present,
  input  logic [63:0]      boot_word,
  input  logic [PPM_W-1:0] scaled_ppm,
  output logic             res_valid,
  output logic [63:0]      result,
  output logic             res_err
);
  localparam int unsigned EXT_W = PPM_W + 8;
  localparam logic [NUM_W-1:0] NOM_NUM = NUM_W'(NS_PER_S) << 32;

  trim_state_e       state_q;
  logic [MUL_W-1:0]  mul_sel;
  logic [PPM_W-1:0]  mag;
  logic [EXT_W-1:0]  ppb_sum;
  logic [EXT_W-1:0]  ppb_wide;
  logic [PPM_W-1:0]  ppb_calc;
  logic              accept;

  logic              neg_q;
  logic [PPM_W-1:0]  ppb_q;
  logic [DEN_W-1:0]  rate_q;
  logic [INC_W-1:0]  nom_q;
  logic              div_start;
  logic              mul_start;

  logic [NUM_W-1:0]  div_num;
  logic [DEN_W-1:0]  div_den;
  logic              div_done;
  logic [NUM_W-1:0]  div_quo;
  logic              mul_done;
  logic [NUM_W-1:0]  mul_prod;

  logic              unused_bits;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    mul_sel  = cfg_present ? boot_word[MUL_LSB +: MUL_W] : MUL_W'(DEF_MUL);
    mag      = scaled_ppm[PPM_W-1] ? PPM_W'(~scaled_ppm + 1'b1) : scaled_ppm;
    ppb_sum  = EXT_W'(mag) + EXT_W'(1);
    ppb_wide = (ppb_sum * EXT_W'(PPB_MUL)) >> PPB_SHIFT;
    ppb_calc = ppb_wide[PPM_W-1:0];
  end

  always_comb begin
    div_num = (state_q == ST_DIV_NOM) ? NOM_NUM : mul_prod;
    div_den = (state_q == ST_DIV_NOM) ? rate_q  : DEN_W'(NS_PER_S);
  end

  assign unused_bits = ^{boot_word, div_quo[NUM_W-1:INC_W], ppb_wide[EXT_W-1:PPM_W]};

  trim_div #(.NW(NUM_W), .DW(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quo   (div_quo)
  );

  trim_mul #(.AW(INC_W), .BW(PPM_W), .PW(NUM_W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mul_start),
    .a     (nom_q),
    .b     (ppb_q),
    .done  (mul_done),
    .prod  (mul_prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      neg_q     <= 1'b0;
      ppb_q     <= '0;
      rate_q    <= '0;
      nom_q     <= '0;
      div_start <= 1'b0;
      mul_start <= 1'b0;
      res_valid <= 1'b0;
      result    <= '0;
      res_err   <= 1'b0;
    end else begin
      div_start <= 1'b0;
      mul_start <= 1'b0;
      res_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (mul_sel == '0) begin
              state_q <= ST_ZERO;
            end else begin
              rate_q    <= DEN_W'(BASE_HZ) * DEN_W'(mul_sel);
              neg_q     <= scaled_ppm[PPM_W-1];
              ppb_q     <= ppb_calc;
              div_start <= 1'b1;
              state_q   <= ST_DIV_NOM;
            end
          end
        end
        ST_DIV_NOM: begin
          if (div_done) begin
            nom_q     <= div_quo[INC_W-1:0];
            mul_start <= 1'b1;
            state_q   <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (mul_done) begin
            div_start <= 1'b1;
            state_q   <= ST_DIV_ADJ;
          end
        end
        ST_DIV_ADJ: begin
          if (div_done) begin
            result    <= neg_q ? (nom_q - div_quo[INC_W-1:0])
                               : (nom_q + div_quo[INC_W-1:0]);
            res_err   <= 1'b0;
            res_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_ZERO: begin
          result    <= '0;
          res_err   <= 1'b1;
          res_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/freq_trim_calc_chk.sv
module freq_trim_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        res_valid,
  input logic [63:0] result,
  input logic        res_err
);

  // R8: completion strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8: outputs move only together with the strobe
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(result) && $stable(res_err)));

  // R6: an error result carries a zero increment
  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (result == 64'd0));

  // R7: taking a request makes the unit busy
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: a result only follows a busy period
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$past(req_ready));

endmodule

bind freq_trim_calc freq_trim_calc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .result    (result),
  .res_err   (res_err)
);

// File: tb/tb_freq_trim_calc.sv
module tb_freq_trim_calc;

  typedef struct packed {
    logic        pres;
    logic [5:0]  mul;
    logic [31:0] ppm;
    logic [63:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  // R1 default multiplier, R2 nominal, R3 ppb boundary, R4 sign, R5 extremes, R6 zero
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd20, 32'd0,          64'h1_0000_0000,  1'b0, 4'd2},  // R2
    '{1'b1, 6'd16, 32'd0,          64'h1_4000_0000,  1'b0, 4'd2},  // R2
    '{1'b1, 6'd1,  32'd0,          64'd85899345920,  1'b0, 4'd2},  // R2
    '{1'b1, 6'd63, 32'd0,          64'd1363481681,   1'b0, 4'd2},  // R2
    '{1'b0, 6'd20, 32'd65536,      64'h1_4000_14F8,  1'b0, 4'd1},  // R1
    '{1'b1, 6'd20, 32'd65536,      64'h1_0000_10C6,  1'b0, 4'd4},  // R4
    '{1'b1, 6'd20, 32'hFFFF_0000,  64'h0_FFFF_EF3A,  1'b0, 4'd4},  // R4
    '{1'b1, 6'd16, 32'hFFFF_0000,  64'h1_3FFF_EB08,  1'b0, 4'd4},  // R4
    '{1'b1, 6'd20, 32'd64,         64'h1_0000_0000,  1'b0, 4'd3},  // R3
    '{1'b1, 6'd20, 32'd65,         64'h1_0000_0004,  1'b0, 4'd3},  // R3
    '{1'b1, 6'd20, 32'hFFFF_FFBF,  64'h0_FFFF_FFFC,  1'b0, 4'd3},  // R3
    '{1'b1, 6'd20, 32'h8000_0000,  64'd4154229808,   1'b0, 4'd5},  // R5
    '{1'b1, 6'd20, 32'h7FFF_FFFF,  64'd4435704784,   1'b0, 4'd5},  // R5
    '{1'b1, 6'd0,  32'd65536,      64'd0,            1'b1, 4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        cfg_present = 1'b0;
  logic [63:0] boot_word = '0;
  logic [31:0] scaled_ppm = '0;
  logic        res_valid;
  logic [63:0] result;
  logic        res_err;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  freq_trim_calc dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .cfg_present (cfg_present),
    .boot_word   (boot_word),
    .scaled_ppm  (scaled_ppm),
    .res_valid   (res_valid),
    .result      (result),
    .res_err     (res_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] mk_word(input logic [5:0] m);
    return ~(64'h3F << 33) | (64'(m) << 33);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic pres, input logic [63:0] word, input logic [31:0] ppm);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_present = pres;
    boot_word   = word;
    scaled_ppm  = ppm;
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid   = 1'b0;
  endtask

  task automatic wait_result(output bit got);
    int n = 0;
    got = 1'b0;
    while (!res_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    got = res_valid;
  endtask

  task automatic run_one(input logic pres, input logic [63:0] word, input logic [31:0] ppm,
                         input logic [63:0] exp, input logic experr, input string tag);
    bit got;
    offer(pres, word, ppm);
    wait_result(got);
    check(got, {tag, " result strobe"}, 64'(got), 64'd1);
    check(result == exp, {tag, " result"}, result, exp);
    check(res_err == experr, {tag, " error flag"}, 64'(res_err), 64'(experr));
    @(negedge clk);
    // R8: strobe gone one cycle later
    check(!res_valid, "R8 strobe width", 64'(res_valid), 64'd0);
  endtask

  initial begin
    bit got;
    int pulses;
    logic [63:0] held;

    repeat (3) @(negedge clk);
    // R9: reset values
    check(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'd1);
    check(res_valid == 1'b0, "R9 strobe after reset", 64'(res_valid), 64'd0);
    check(result == 64'd0, "R9 result after reset", result, 64'd0);
    check(res_err == 1'b0, "R9 error after reset", 64'(res_err), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
      run_one(VECS[i].pres, mk_word(VECS[i].mul), VECS[i].ppm, VECS[i].exp, VECS[i].err, tag);
    end

    // R7: requests offered while busy are ignored
    offer(1'b1, mk_word(6'd20), 32'd65536);
    pulses = 0;
    cfg_present = 1'b1;
    boot_word   = mk_word(6'd0);
    scaled_ppm  = 32'hFFFF_0000;
    req_valid   = 1'b1;
    got = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (req_ready) got = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(got, "R7 ready low while busy", 64'(got), 64'd1);
    wait_result(got);
    check(got && result == 64'h1_0000_10C6, "R7 busy request left result intact", result, 64'h1_0000_10C6);
    check(res_err == 1'b0, "R7 busy request left error clear", 64'(res_err), 64'd0);
    @(negedge clk);
    for (int k = 0; k < 400; k++) begin
      if (res_valid) pulses++;
      @(negedge clk);
    end
    check(pulses == 0, "R7 no second calculation started", 64'(pulses), 64'd0);

    // R6: error raised, then cleared by a good calculation
    run_one(1'b1, mk_word(6'd0), 32'd0, 64'd0, 1'b1, "R6 zero multiplier");
    run_one(1'b1, mk_word(6'd16), 32'd0, 64'h1_4000_0000, 1'b0, "R6 error cleared");

    // R1: absent configuration ignores the word even with a zero field
    run_one(1'b0, mk_word(6'd0), 32'd0, 64'h1_4000_0000, 1'b0, "R1 word ignored");

    // R8: outputs hold while idle and inputs move
    held = result;
    for (int k = 0; k < 20; k++) begin
      scaled_ppm = 32'(k * 977);
      boot_word  = mk_word(6'(k));
      @(negedge clk);
    end
    check(result == held && !res_valid, "R8 result holds while idle", result, held);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule